// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Event Interrupt

This block is a 32-bit down-counter that software controls through a small word-addressed register bus. Software writes a start value, then picks a mode and a prescaler divide value and turns the counter on. While it runs, the counter steps down once every prescaler-value-plus-one clock cycles. When it reaches zero, it raises a sticky event flag. In one-shot mode the counter then stays at zero. In auto-reload mode it restarts from the stored start value on the next step, which gives a periodic event.

The event flag drives one level-sensitive interrupt line, and an interrupt-enable bit masks that line. Software clears the flag by writing a one to it. A one-shot run is started as follows: clear the flag, write the control word with the counter off, write the start value (which also loads the counter), then turn the counter on.

Top module: `cnt_timer`

## Requirements
- R1: Word registers are selected by address bits 3:2, and address bits 1:0 are ignored. The registers are: start value at 0x0 (read back as written), live count at 0x4, control at 0x8, and status at 0xC. Control holds run at bit 0, auto-reload at bit 1, interrupt enable at bit 2 and the prescaler at bits 15:8. All other control bits and status bits 31:1 read as 0.
- R2: After reset, every register reads 0 and the interrupt output is 0.
- R3: While run is 0, the count does not change except through a start-value write.
- R4: While run is 1, the count steps once every (prescaler+1) cycles. The prescaler phase restarts when run is 0 and when the start value is written, so the first step after run goes from 0 to 1 lands (prescaler+1) cycles after that control write. A phase that has reached or passed a newly lowered prescaler value steps at once.
- R5: Writing the start value also loads the count on the same edge, and this write takes priority over a step in that cycle.
- R6: In one-shot mode (bit 1 = 0), a count of zero stays at zero on later steps.
- R7: In auto-reload mode (bit 1 = 1), a step taken while the count is zero reloads the count from the start-value register. That step does not set the event flag.
- R8: The event flag (status bit 0) is set by a step that takes the count from 1 to 0. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it unchanged.
- R9: If a clear of the flag and a setting step occur in the same cycle, the flag ends up set.
- R10: The interrupt output equals the event flag while the interrupt enable is 1, and is 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt, event flag gated by the enable |

## Verification
The hardest case to reach is a flag clear that lands in exactly the cycle where the counter steps from 1 to 0. The bench produces it with a directed one-shot run using prescaler 0, placing the status write a fixed number of cycles after the run write. The exact cycle of the first event under a non-zero prescaler is also timed directly. Random writes of small start values and small prescalers cause frequent zero crossings, reloads and mode changes during a run. Every read and every interrupt sample is compared with a cycle model kept in the bench.

// File: rtl/cnt_timer_pkg.sv
package cnt_timer_pkg;

    // word select taken from address bits 3:2
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int unsigned CTRL_RUN_BIT    = 0;
    localparam int unsigned CTRL_RELOAD_BIT = 1;
    localparam int unsigned CTRL_IE_BIT     = 2;
    localparam int unsigned CTRL_PSC_LSB    = 8;

    // status word bit positions
    localparam int unsigned STAT_EVENT_BIT  = 0;

endpackage

// File: rtl/cnt_timer_regs.sv
module cnt_timer_regs
    import cnt_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic              ev_flag,
    output logic              start_wr,
    output logic              stat_clr,
    output logic [DATA_W-1:0] start_val,
    output logic              run,
    output logic              reload,
    output logic              irq_en,
    output logic [PSC_W-1:0]  psc
);

    localparam int unsigned PSC_MSB = CTRL_PSC_LSB + PSC_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] start;
        logic              run;
        logic              reload;
        logic              ie;
        logic [PSC_W-1:0]  psc;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     wr_ctrl;

    always_comb begin
        sel      = reg_sel_e'(bus_addr[3:2]);
        start_wr = bus_we && (sel == SEL_START);
        wr_ctrl  = bus_we && (sel == SEL_CTRL);
        stat_clr = bus_we && (sel == SEL_STAT) && bus_wdata[STAT_EVENT_BIT];

        r_d = r_q;
        if (start_wr) begin
            r_d.start = bus_wdata;
        end
        if (wr_ctrl) begin
            r_d.run    = bus_wdata[CTRL_RUN_BIT];
            r_d.reload = bus_wdata[CTRL_RELOAD_BIT];
            r_d.ie     = bus_wdata[CTRL_IE_BIT];
            r_d.psc    = bus_wdata[PSC_MSB:CTRL_PSC_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_START: bus_rdata = r_q.start;
            SEL_COUNT: bus_rdata = cnt_val;
            SEL_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]          = r_q.run;
                bus_rdata[CTRL_RELOAD_BIT]       = r_q.reload;
                bus_rdata[CTRL_IE_BIT]           = r_q.ie;
                bus_rdata[PSC_MSB:CTRL_PSC_LSB]  = r_q.psc;
            end
            SEL_STAT: bus_rdata[STAT_EVENT_BIT] = ev_flag;
            default:  bus_rdata = '0;
        endcase
    end

    assign start_val = r_q.start;
    assign run       = r_q.run;
    assign reload    = r_q.reload;
    assign irq_en    = r_q.ie;
    assign psc       = r_q.psc;

endmodule

// File: rtl/cnt_timer_presc.sv
module cnt_timer_presc #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] phase;
    } presc_t;

    presc_t p_d, p_q;
    logic   wrap;

    always_comb begin
        wrap = (p_q.phase >= psc);
        tick = run && wrap;
        p_d  = p_q;
        if (!run || restart) begin
            p_d.phase = '0;
        end else if (wrap) begin
            p_d.phase = '0;
        end else begin
            p_d.phase = p_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/cnt_timer_core.sv
module cnt_timer_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] start_val,
    input  logic              reload,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] cnt_val,
    output logic              ev_flag
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              ev;
    } core_t;

    core_t c_d, c_q;
    logic  step, hit_zero;

    always_comb begin
        step     = tick && !start_wr;
        hit_zero = step && (c_q.cnt == ONE);
        c_d      = c_q;

        if (start_wr) begin
            c_d.cnt = wdata;
        end else if (step) begin
            if (c_q.cnt != '0) begin
                c_d.cnt = c_q.cnt - ONE;
            end else if (reload) begin
                c_d.cnt = start_val;
            end
        end

        if (stat_clr) begin
            c_d.ev = 1'b0;
        end
        if (hit_zero) begin
            c_d.ev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_val = c_q.cnt;
    assign ev_flag = c_q.ev;

endmodule

// File: rtl/cnt_timer.sv
module cnt_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              start_wr;
    logic              stat_clr;
    logic [DATA_W-1:0] start_val;
    logic              run;
    logic              reload;
    logic              irq_en;
    logic [PSC_W-1:0]  psc;
    logic              tick;
    logic [DATA_W-1:0] cnt_val;
    logic              ev_flag;

    cnt_timer_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PSC_W  (PSC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_val),
        .ev_flag   (ev_flag),
        .start_wr  (start_wr),
        .stat_clr  (stat_clr),
        .start_val (start_val),
        .run       (run),
        .reload    (reload),
        .irq_en    (irq_en),
        .psc       (psc)
    );

    cnt_timer_presc #(
        .PSC_W (PSC_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (start_wr),
        .psc     (psc),
        .tick    (tick)
    );

    cnt_timer_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_wr  (start_wr),
        .wdata     (bus_wdata),
        .start_val (start_val),
        .reload    (reload),
        .stat_clr  (stat_clr),
        .cnt_val   (cnt_val),
        .ev_flag   (ev_flag)
    );

    assign irq = ev_flag && irq_en;

endmodule

// File: rtl/cnt_timer_chk.sv
module cnt_timer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] cnt_val,
    input logic              ev_flag,
    input logic              run,
    input logic              reload,
    input logic              irq_en
);

    logic wr_start, wr_clr;
    assign wr_start = bus_we && (bus_addr[3:2] == 2'd0);
    assign wr_clr   = bus_we && (bus_addr[3:2] == 2'd3) && bus_wdata[0];

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_start) |=> $stable(cnt_val)); // R3

    AST_START_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (cnt_val == $past(bus_wdata))); // R5

    AST_ONESHOT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload && cnt_val == '0 && !wr_start) |=> (cnt_val == '0)); // R6

    AST_FLAG_FALLS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ev_flag) |-> $past(wr_clr)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R10

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |-> (irq == ev_flag)); // R10

endmodule

bind cnt_timer cnt_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt_val   (cnt_val),
    .ev_flag   (ev_flag),
    .run       (run),
    .reload    (reload),
    .irq_en    (irq_en)
);

// File: tb/test_cnt_timer.sv
module test_cnt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the register state
    logic [31:0] m_start, m_cnt;
    logic        m_run, m_rl, m_ie, m_ev;
    logic [7:0]  m_psc, m_ph;

    logic [31:0] rd_val;
    logic        irq_seen;

    always #10 clk = ~clk;   // 50 MHz

    cnt_timer i_cnt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return m_start;
            2'd1:    return m_cnt;
            2'd2:    return {16'h0, m_psc, 5'h0, m_ie, m_rl, m_run};
            default: return {31'h0, m_ev};
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        case (a[3:2])
            2'd1:    return "R5 count read";
            2'd3:    return "R8 status read";
            default: return "R1 register read";
        endcase
    endfunction

    task automatic model_reset();
        m_start = '0; m_cnt = '0; m_run = 0; m_rl = 0; m_ie = 0; m_ev = 0;
        m_psc = '0; m_ph = '0;
    endtask

    task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d);
        logic tk, sw, clr, setf;
        logic [31:0] nc;
        logic [7:0]  nph;
        sw   = we && a[3:2] == 2'd0;
        clr  = we && a[3:2] == 2'd3 && d[0];
        tk   = m_run && (m_ph >= m_psc);
        nph  = (!m_run || sw || m_ph >= m_psc) ? 8'h0 : m_ph + 8'h1;
        nc   = m_cnt;
        setf = 1'b0;
        if (sw) nc = d;
        else if (tk) begin
            if (m_cnt != 0) begin
                nc = m_cnt - 1;
                setf = (m_cnt == 1);
            end else if (m_rl) nc = m_start;
        end
        if (clr) m_ev = 1'b0;
        if (setf) m_ev = 1'b1;
        m_cnt = nc;
        m_ph  = nph;
        if (sw) m_start = d;
        if (we && a[3:2] == 2'd2) begin
            m_run = d[0]; m_rl = d[1]; m_ie = d[2]; m_psc = d[15:8];
        end
    endtask

    // one bus cycle: drive, sample away from the edge, then advance the model
    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        rd_val   = bus_rdata;
        irq_seen = irq;
        chk(read_tag(a), bus_rdata, exp_read(a));
        chk("R10 irq level", {31'h0, irq}, {31'h0, m_ev & m_ie});
        @(posedge clk);
        model_step(we, a, d);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic rd(input logic [3:0] a);
        cyc(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int first;
        logic [31:0] held;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state on every register
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a));
            chk("R2 reset value", rd_val, 32'h0);
            chk("R2 reset irq", {31'h0, irq_seen}, 32'h0);
        end

        // R4 R6: one-shot, start 4, prescaler 2, first event timed
        wr(4'hC, 32'h1);
        wr(4'h8, 32'h0000_0200);
        wr(4'h0, 32'd4);
        wr(4'h8, 32'h0000_0205);
        first = -1;
        for (int n = 1; n <= 30; n++) begin
            rd(4'hC);
            if (irq_seen && first < 0) first = n;
        end
        chk("R4 first event cycle", 32'(first), 32'd13);
        rd(4'h4);
        chk("R6 one-shot holds zero", rd_val, 32'h0);

        // R1: address bits 1:0 ignored, start value readback
        rd(4'h3);
        chk("R1 aliased start read", rd_val, 32'd4);
        rd(4'hB);
        chk("R1 control readback", rd_val, 32'h0000_0205);

        // R8: writing zero keeps the flag, writing one clears it
        wr(4'hC, 32'h0);
        rd(4'hC);
        chk("R8 write zero keeps flag", rd_val, 32'h1);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC);
        chk("R8 write one clears flag", rd_val, 32'h0);

        // R3: stopping holds the count
        wr(4'h0, 32'd50);
        wr(4'h8, 32'h0000_0001);
        repeat (5) rd(4'h4);
        wr(4'h8, 32'h0);
        rd(4'h4);
        held = rd_val;
        repeat (6) rd(4'h0);
        rd(4'h4);
        chk("R3 count held while off", rd_val, held);

        // R5: start write wins over a step while running
        wr(4'h8, 32'h0000_0001);
        rd(4'h4);
        wr(4'h0, 32'd100);
        rd(4'h4);
        chk("R5 start write loads count", rd_val, 32'd100);

        // R7: auto-reload from start value 3, prescaler 0
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h1);
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h0000_0003);
        rd(4'h4); rd(4'h4); rd(4'h4);
        rd(4'h4);
        chk("R7 count reached zero", rd_val, 32'd0);
        rd(4'h4);
        chk("R7 reload after zero", rd_val, 32'd3);

        // R10: masking of the interrupt line
        rd(4'hC);
        chk("R8 event set in reload mode", rd_val, 32'h1);
        wr(4'h8, 32'h0000_0002);
        rd(4'h0);
        chk("R10 masked irq", {31'h0, irq_seen}, 32'h0);
        wr(4'h8, 32'h0000_0006);
        rd(4'h0);
        chk("R10 unmasked irq", {31'h0, irq_seen}, 32'h1);

        // R9: clear lands in the cycle the count goes 1 -> 0
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h1);
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h0000_0001);
        rd(4'h4);
        rd(4'h4);
        wr(4'hC, 32'h1);
        rd(4'hC);
        chk("R9 set wins over clear", rd_val, 32'h1);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom % 16;
            if (r == 8)       wr(4'h0, $urandom % 8);
            else if (r == 9)  wr(4'h8, {16'h0, 8'($urandom % 4), 5'h0, 3'($urandom)});
            else if (r == 10) wr(4'hC, 32'($urandom % 2));
            else              rd(4'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule